// File: doc/BRIEF.md
# Processor interrupt level arbiter

This block decides which external interrupt level a processor core should take next. It forms an effective pending vector from sixteen external level lines and a software-interrupt register that the block holds. It compares that vector against the core's current interrupt-level threshold and produces a registered hard-interrupt request together with the trap type to take. A pending vector-interrupt request outranks every level. A new level is held back while a higher-typed external-interrupt trap is already being serviced at a nonzero trap level.

The software-interrupt register is written through three strobes: OR-in, AND-NOT and overwrite, all sharing one data bus. Two bits of the register act as timer flags. They are kept out of the level vector, and either one makes level 14 pending.

A small state machine holds the outcome. `ARB_IDLE` means no request. `ARB_EXT` means an external level has been granted. `ARB_VEC` means the vector interrupt has been granted.

Transitions are evaluated every cycle, in this priority order:
- `to_vec`: a vector request is pending. Any state goes to `ARB_VEC`.
- `withdraw`: no level is eligible, or interrupts are disabled. Any state goes to `ARB_IDLE`.
- `hold`: the candidate is suppressed. The state and type stay as they are.
- `grant`: any other case. Any state goes to `ARB_EXT` with the candidate type.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset the request output is 0 and the type output is 0, and the software-interrupt register is 0.
- R2: The effective pending vector is `ext_level_i` ORed with bits [15:0] of the software-interrupt register, with bit 0 forced to 0. Level 0 is never selected.
- R3: If software-interrupt bit 0 or bit 16 (the timer flags) is set, level 14 is pending.
- R4: When `vec_pend_i` is 1, the next outputs are request 1 and type 9'h060, whether interrupts are enabled or not.
- R5: With no vector request, if the effective vector (as a 17-bit number) is below 2 shifted left by `thresh_i`, the next outputs are request 0 and type 0.
- R6: With interrupts enabled and no vector request, the highest set level L above `thresh_i` is granted: request 1, type 9'h040 | L.
- R7: If `trap_lvl_i` is nonzero, `trap_type_i[8:4]` equals 5'h04 and `trap_type_i` is greater than the candidate type, no grant is made. Request and type keep their previous values.
- R8: With no vector request and `irq_en_i` at 0, the next outputs are request 0 and type 0.
- R9: At each clock edge the software-interrupt register takes a new value. `sw_wr_i` overwrites it with `sw_data_i`. Otherwise `sw_set_i` ORs in `sw_data_i`, and `sw_clr_i` clears the bits set in `sw_data_i`, with clear winning over set. Rewriting the same value leaves the outputs unchanged.
- R10: The outputs are registered. They reflect the level, threshold, enable and trap inputs one cycle after those inputs change, and a software-register operation two cycles after its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_level_i | input | 16 | External pending levels, bit n is level n |
| thresh_i | input | 4 | Current interrupt-level threshold |
| irq_en_i | input | 1 | Global interrupt enable |
| vec_pend_i | input | 1 | Vector interrupt pending |
| trap_lvl_i | input | 3 | Current trap level |
| trap_type_i | input | 9 | Trap type saved at the current trap level |
| sw_set_i | input | 1 | OR `sw_data_i` into the software register |
| sw_clr_i | input | 1 | Clear the software-register bits set in `sw_data_i` |
| sw_wr_i | input | 1 | Overwrite the software register with `sw_data_i` |
| sw_data_i | input | 17 | Data for the software-register operations |
| irq_req_o | output | 1 | Hard-interrupt request |
| irq_type_o | output | 9 | Selected trap type |

## Verification
The hardest case to reach is the hold transition. Here a candidate is eligible but suppressed by an in-progress external-interrupt trap, and the outputs must keep a grant made earlier under different inputs. The stimulus first grants a high level with a zero trap level. It then lowers the external level and presents a nonzero trap level with a higher external-group stored type, and checks that the old type stays. It also covers hold from the idle state, a stored type outside the group, and a stored type below the candidate. A bench-side model tracks the previous outcome. This lets every cycle, including software-register strobes, be checked against a queued expectation.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_EXT  = 2'd1,
        ARB_VEC  = 2'd2
    } arb_state_e;

    typedef enum logic [1:0] {
        SW_NOP = 2'd0,
        SW_OR  = 2'd1,
        SW_AND = 2'd2,
        SW_PUT = 2'd3
    } sw_op_e;

endpackage

// File: rtl/irq_softint_reg.sv
module irq_softint_reg #(
    parameter int SW_W = 17
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_i,
    input  logic            clr_i,
    input  logic            wr_i,
    input  logic [SW_W-1:0] data_i,
    output logic [SW_W-1:0] sw_o
);
    import irq_arb_pkg::*;

    logic [SW_W-1:0] sw_q;
    logic [SW_W-1:0] sw_d;
    sw_op_e          op;

    // Dominant operation: overwrite, else combined OR / AND-NOT.
    always_comb begin
        if (wr_i)
            op = SW_PUT;
        else if (clr_i)
            op = SW_AND;
        else if (set_i)
            op = SW_OR;
        else
            op = SW_NOP;
    end

    always_comb begin
        unique case (op)
            SW_PUT:  sw_d = data_i;
            SW_AND:  sw_d = (sw_q | (set_i ? data_i : '0)) & ~data_i;
            SW_OR:   sw_d = sw_q | data_i;
            default: sw_d = sw_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            sw_q <= '0;
        else
            sw_q <= sw_d;
    end

    assign sw_o = sw_q;

    // R9: an overwrite lands exactly on the next edge
    p_overwrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> sw_q == $past(data_i));

    // R9: a clear strobe leaves no cleared bit standing
    p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !wr_i) |=> (sw_q & $past(data_i)) == '0);

endmodule

// File: rtl/irq_level_scan.sv
module irq_level_scan #(
    parameter int NLVL      = 16,
    parameter int SW_W      = NLVL + 1,
    parameter int TIMER_LVL = 14,
    localparam int LVL_W    = $clog2(NLVL)
) (
    input  logic [NLVL-1:0]  ext_i,
    input  logic [SW_W-1:0]  sw_i,
    input  logic [LVL_W-1:0] thresh_i,
    output logic [NLVL-1:0]  eff_o,
    output logic             eligible_o,
    output logic [LVL_W-1:0] cand_o
);
    logic            timer_hit;
    logic [NLVL-1:0] sw_lvl;
    logic [NLVL:0]   limit;

    // Timer flags occupy bit 0 and the top bit; both are kept out of the
    // level vector and instead raise the timer level.
    assign timer_hit = sw_i[0] | sw_i[SW_W-1];

    genvar g;
    generate
        for (g = 0; g < NLVL; g++) begin : g_mask
            if (g == 0) begin : g_tmr
                assign sw_lvl[g] = 1'b0;
            end else if (g == TIMER_LVL) begin : g_tlvl
                assign sw_lvl[g] = sw_i[g] | timer_hit;
            end else begin : g_pass
                assign sw_lvl[g] = sw_i[g];
            end
        end
    endgenerate

    assign eff_o      = ext_i | sw_lvl;
    assign limit      = (NLVL+1)'(2) << thresh_i;
    assign eligible_o = {1'b0, eff_o} >= limit;

    // Highest set level above the threshold; later iterations override.
    always_comb begin
        cand_o = '0;
        for (int i = 1; i < NLVL; i++) begin
            if (eff_o[i] && ((LVL_W+1)'(i) > {1'b0, thresh_i}))
                cand_o = LVL_W'(i);
        end
    end

endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter #(
    parameter int            NLVL      = 16,
    parameter int            TT_W      = 9,
    parameter int            TL_W      = 3,
    parameter int            TIMER_LVL = 14,
    parameter logic [8:0]    EXT_BASE  = 9'h040,
    parameter logic [8:0]    VEC_TYPE  = 9'h060,
    localparam int           LVL_W     = $clog2(NLVL),
    localparam int           SW_W      = NLVL + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [15:0]      ext_level_i,
    input  logic [3:0]       thresh_i,
    input  logic             irq_en_i,
    input  logic             vec_pend_i,
    input  logic [2:0]       trap_lvl_i,
    input  logic [8:0]       trap_type_i,
    input  logic             sw_set_i,
    input  logic             sw_clr_i,
    input  logic             sw_wr_i,
    input  logic [16:0]      sw_data_i,
    output logic             irq_req_o,
    output logic [8:0]       irq_type_o
);
    import irq_arb_pkg::*;

    logic [SW_W-1:0]  sw;
    logic [NLVL-1:0]  eff;
    logic             eligible;
    logic [LVL_W-1:0] cand_lvl;
    logic [TT_W-1:0]  cand_type;
    logic             in_ext_trap;
    logic             suppress;

    arb_state_e       state_q, state_d;
    logic [TT_W-1:0]  type_q, type_d;

    irq_softint_reg #(.SW_W(SW_W)) i_sw (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (sw_set_i),
        .clr_i  (sw_clr_i),
        .wr_i   (sw_wr_i),
        .data_i (sw_data_i),
        .sw_o   (sw)
    );

    irq_level_scan #(.NLVL(NLVL), .SW_W(SW_W), .TIMER_LVL(TIMER_LVL)) i_scan (
        .ext_i      (ext_level_i),
        .sw_i       (sw),
        .thresh_i   (thresh_i),
        .eff_o      (eff),
        .eligible_o (eligible),
        .cand_o     (cand_lvl)
    );

    assign cand_type   = EXT_BASE | TT_W'(cand_lvl);
    assign in_ext_trap = (trap_lvl_i != '0) &&
                         (trap_type_i[TT_W-1:LVL_W] == EXT_BASE[TT_W-1:LVL_W]);
    assign suppress    = in_ext_trap && (trap_type_i > cand_type);

    // Next-state: to_vec, withdraw, hold, grant in priority order.
    always_comb begin
        state_d = state_q;
        type_d  = type_q;
        if (vec_pend_i) begin
            state_d = ARB_VEC;
            type_d  = VEC_TYPE;
        end else if (!eligible || !irq_en_i) begin
            state_d = ARB_IDLE;
            type_d  = '0;
        end else if (!suppress) begin
            state_d = ARB_EXT;
            type_d  = cand_type;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            type_q  <= '0;
        end else begin
            state_q <= state_d;
            type_q  <= type_d;
        end
    end

    // Output decode from the state register.
    always_comb begin
        unique case (state_q)
            ARB_EXT, ARB_VEC: irq_req_o = 1'b1;
            default:          irq_req_o = 1'b0;
        endcase
        irq_type_o = type_q;
    end

    // R4: a vector request always wins on the next edge
    p_vec_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_pend_i |=> (irq_req_o && irq_type_o == VEC_TYPE));

    // R5: nothing above the threshold clears the outputs
    p_below_thresh_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!vec_pend_i && !eligible) |=> (!irq_req_o && irq_type_o == '0));

    // R8: disabled interrupts clear the outputs
    p_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!vec_pend_i && !irq_en_i) |=> (!irq_req_o && irq_type_o == '0));

    // R2/R6: a request never carries a zero type or level 0
    p_type_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (irq_type_o != '0 && irq_type_o != EXT_BASE));

    // R3: a timer flag with a low threshold grants level 14 or above
    p_timer_lvl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((sw[0] || sw[SW_W-1]) && irq_en_i && !vec_pend_i &&
         trap_lvl_i == '0 && thresh_i < 4'(TIMER_LVL))
        |=> (irq_req_o && irq_type_o[LVL_W-1:0] >= LVL_W'(TIMER_LVL)));

    // R7: a suppressed candidate keeps the outputs steady
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!vec_pend_i && eligible && irq_en_i && suppress)
        |=> ($stable(irq_type_o) && $stable(irq_req_o)));

endmodule

// File: tb/test_irq_level_arbiter.sv
module test_irq_level_arbiter;

    typedef struct {
        logic       req;
        logic [8:0] typ;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ext = '0;
    logic [3:0]  thr = '0;
    logic        en = 1'b0;
    logic        vec = 1'b0;
    logic [2:0]  tl = '0;
    logic [8:0]  tt = '0;
    logic        s_set = 1'b0, s_clr = 1'b0, s_wr = 1'b0;
    logic [16:0] s_data = '0;
    logic        req;
    logic [8:0]  typ;

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    exp_t sb[$];

    logic        m_req = 1'b0;
    logic [8:0]  m_type = '0;
    logic [16:0] m_sw = '0;

    always #5 clk = ~clk;

    irq_level_arbiter i_irq_level_arbiter (
        .clk(clk), .rst_n(rst_n), .ext_level_i(ext), .thresh_i(thr),
        .irq_en_i(en), .vec_pend_i(vec), .trap_lvl_i(tl), .trap_type_i(tt),
        .sw_set_i(s_set), .sw_clr_i(s_clr), .sw_wr_i(s_wr), .sw_data_i(s_data),
        .irq_req_o(req), .irq_type_o(typ)
    );

    // Model of the next outcome, written from the requirements.
    task automatic model_next();
        logic [15:0] eff;
        int          lvl;
        logic [8:0]  cand;
        eff = ext | (m_sw[15:0] & 16'hFFFE);
        if (m_sw[0] || m_sw[16]) eff[14] = 1'b1;
        if (vec) begin
            m_req = 1'b1; m_type = 9'h060;
        end else if ({1'b0, eff} < (17'd2 << thr) || !en) begin
            m_req = 1'b0; m_type = '0;
        end else begin
            lvl = 0;
            for (int i = 15; i > int'(thr); i--)
                if (eff[i] && lvl == 0) lvl = i;
            cand = 9'h040 | 9'(lvl);
            if (!(tl != 0 && tt[8:4] == 5'h04 && tt > cand)) begin
                m_req = 1'b1; m_type = cand;
            end
        end
    endtask

    // Driver: one cycle of stimulus, pushes the expected result.
    task automatic step(string tag, bit op_set = 0, bit op_clr = 0,
                        bit op_wr = 0, logic [16:0] d = '0);
        exp_t e;
        s_set = op_set; s_clr = op_clr; s_wr = op_wr; s_data = d;
        model_next();
        e.req = m_req; e.typ = m_type; e.tag = tag;
        sb.push_back(e);
        if (op_wr) m_sw = d;
        else if (op_set || op_clr)
            m_sw = (m_sw | (op_set ? d : 17'h0)) & ~(op_clr ? d : 17'h0);
        @(posedge clk);
        @(negedge clk);
        s_set = 0; s_clr = 0; s_wr = 0;
    endtask

    // Monitor: compares after each edge.
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (req !== e.req || typ !== e.typ) begin
                errors++;
                $display("FAIL %s: req=%0b type=%03h expected req=%0b type=%03h",
                         e.tag, req, typ, e.req, e.typ);
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        checks++;
        if (req !== 1'b0 || typ !== 9'h000) begin
            errors++;
            $display("FAIL R1 reset: req=%0b type=%03h expected req=0 type=000", req, typ);
        end

        en = 1; thr = 0;
        step("R1 idle after reset");
        ext = 16'h0020;  step("R6 R10 level 5");
        ext = 16'h1208; thr = 2; step("R6 highest of 3,9,12");
        thr = 12; step("R5 below threshold 12");
        thr = 11; step("R6 level 12 above 11");
        en = 0;   step("R8 disabled withdraws");
        vec = 1;  step("R4 vector while disabled");
        en = 1;   step("R4 vector over levels");
        vec = 0;  step("R6 back to level 12");
        thr = 0; ext = 16'h0002; step("R2 level 1");
        ext = 16'h0001; step("R2 level 0 never chosen");
        thr = 15; ext = 16'hFFFF; step("R5 threshold 15 blocks all");

        thr = 0; ext = '0;
        step("R9 set issued", 1, 0, 0, 17'h00080);
        step("R9 R10 set visible level 7");
        step("R9 set bit 10", 1, 0, 0, 17'h00400);
        step("R9 set 10 visible");
        step("R9 clear bit 10", 0, 1, 0, 17'h00400);
        step("R9 clear visible");
        step("R9 clear beats set", 1, 1, 0, 17'h00080);
        step("R9 both strobes visible");
        step("R3 write bit 16", 0, 0, 1, 17'h10000);
        step("R3 timer bit 16 gives 14");
        step("R9 same value rewrite", 0, 0, 1, 17'h10000);
        step("R9 rewrite no change");
        step("R3 write bit 0", 0, 0, 1, 17'h00001);
        step("R3 timer bit 0 gives 14");
        thr = 14; step("R3 R2 bit 0 not a level");
        thr = 0;
        step("R9 overwrite wins", 1, 1, 1, 17'h08000);
        step("R9 overwrite level 15");
        step("R9 write zero", 0, 0, 1, 17'h00000);
        step("R9 zero visible");

        ext = 16'h0200; step("R7 prep level 9");
        ext = 16'h0020; tl = 1; tt = 9'h04A; step("R7 hold level 9");
        tl = 0; step("R7 trap level 0 grants 5");
        tl = 2; tt = 9'h041; step("R7 lower stored type grants");
        tt = 9'h0A0; step("R7 outside group grants");
        ext = '0; step("R5 clear to idle");
        ext = 16'h0020; tt = 9'h04F; step("R7 hold from idle");
        tl = 0; step("R7 release grants 5");
        ext = 16'h8000; tl = 3; tt = 9'h04E; step("R7 higher candidate grants");

        repeat (2) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule